// File: doc/BRIEF.md
# MMU Fault Status Capture Unit

This block records memory-access faults for a simple reference MMU. When the access path detects a fault, it pulses a strobe along with the faulting address and three qualifiers: write, instruction fetch, and alternate-space access. The block captures these in two registers. The status register holds a packed word describing the fault. The address register holds the full faulting address.

If a second fault arrives before software has read the status register, the new word marks overflow in bit 0. All other status bits describe only the newest fault. A data-access trap request is raised for the fault only when the MMU is enabled and no-fault mode is off. Otherwise the fault is recorded silently.

Software reads the status register through a read strobe. The value is visible on the output during the strobe cycle, and the register clears at the following edge. The address register is read-only and is not cleared by a read.

Top module: `mmu_fault_capture`

## Requirements
- R1: When a fault is captured while the status register is non-zero, the new status word has bit 0 (overflow) set. When the register was zero, bit 0 of the new word is 0.
- R2: Bit 16 of the captured status word equals the alternate-space qualifier of the fault.
- R3: Bit 5 of the captured status word equals the supervisor-mode input at the time of the fault.
- R4: Bit 6 of the captured status word equals the fetch qualifier, and bit 7 equals the write qualifier.
- R5: Every captured status word has bits 4:2 equal to 5 and bit 1 (address valid) set. All bits not named in R1 to R5 are 0.
- R6: The address register loads the full faulting address on every fault. It keeps its value otherwise, including across a status read.
- R7: `trap_o` is high for exactly the one cycle after a fault whose `mmu_en_i` was 1 and `mmu_nofault_i` was 0. It is low in every other cycle.
- R8: While `stat_rd_i` is high, `stat_o` shows the current status. If no fault arrives in that cycle, the status register reads zero from the next cycle on.
- R9: When a fault and a status read occur in the same cycle, the fault update wins: the register holds the new fault word (R1 to R5) and is not cleared.
- R10: An active-low asynchronous reset clears the status register, the address register and the trap request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flt_valid_i | input | 1 | Fault strobe, one per faulting access |
| flt_addr_i | input | ADDR_W | Faulting address |
| flt_write_i | input | 1 | Faulting access was a write |
| flt_fetch_i | input | 1 | Faulting access was an instruction fetch |
| flt_alt_i | input | 1 | Faulting access used an alternate address space |
| sup_mode_i | input | 1 | Processor is in supervisor mode |
| mmu_en_i | input | 1 | MMU enable control bit |
| mmu_nofault_i | input | 1 | MMU no-fault control bit |
| stat_rd_i | input | 1 | Status read strobe (read-to-clear) |
| stat_o | output | STAT_W | Fault status register |
| addr_o | output | ADDR_W | Fault address register |
| trap_o | output | 1 | Data-access trap request pulse |

## Verification
The assertions assume that the qualifiers, mode and control inputs are valid whenever `flt_valid_i` is high. They also assume the fault strobe and read strobe are synchronous single-cycle levels sampled at the rising edge. The bench drives every input at the falling edge and holds it for exactly one cycle. It returns the strobes to zero between operations, so each captured word depends only on the cycle it was driven in. Back-to-back faults and a fault coinciding with a read are applied on purpose, to reach the overflow and priority paths within those same rules.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  localparam int unsigned OVF_BIT   = 0;
  localparam int unsigned AVAL_BIT  = 1;
  localparam int unsigned TYPE_LO   = 2;
  localparam int unsigned TYPE_HI   = 4;
  localparam int unsigned SUP_BIT   = 5;
  localparam int unsigned FETCH_BIT = 6;
  localparam int unsigned WR_BIT    = 7;
  localparam int unsigned ALT_BIT   = 16;
  localparam int unsigned TYPE_W    = TYPE_HI - TYPE_LO + 1;

  typedef struct packed {
    logic alt;
    logic sup;
    logic fetch;
    logic wr;
  } flt_attr_t;
endpackage

// File: rtl/mfc_stat_build.sv
module mfc_stat_build
  import mfc_pkg::*;
#(
  parameter int unsigned STAT_W  = 32,
  parameter int unsigned FT_CODE = 5
) (
  input  logic              prev_nz_i,
  input  flt_attr_t         attr_i,
  output logic [STAT_W-1:0] word_o
);
  always_comb begin
    word_o                  = '0;
    word_o[OVF_BIT]         = prev_nz_i;
    word_o[AVAL_BIT]        = 1'b1;
    word_o[TYPE_HI:TYPE_LO] = TYPE_W'(FT_CODE);
    word_o[SUP_BIT]         = attr_i.sup;
    word_o[FETCH_BIT]       = attr_i.fetch;
    word_o[WR_BIT]          = attr_i.wr;
    word_o[ALT_BIT]         = attr_i.alt;
  end

  always_comb begin
    AST_TYPE_CONST: assert (word_o[TYPE_HI:TYPE_LO] == TYPE_W'(FT_CODE) && word_o[AVAL_BIT]); // R5
  end
endmodule

// File: rtl/mfc_regs.sv
module mfc_regs #(
  parameter int unsigned STAT_W = 32,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flt_valid_i,
  input  logic [ADDR_W-1:0] flt_addr_i,
  input  logic [STAT_W-1:0] new_word_i,
  input  logic              rd_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [STAT_W-1:0] stat_q;
  logic [ADDR_W-1:0] addr_q;

  // fault wins over read-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          stat_q <= '0;
    else if (flt_valid_i) stat_q <= new_word_i;
    else if (rd_i)        stat_q <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          addr_q <= '0;
    else if (flt_valid_i) addr_q <= flt_addr_i;
  end

  assign stat_o = stat_q;
  assign addr_o = addr_q;

  AST_ADDR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_valid_i |=> addr_q == $past(flt_addr_i)); // R6
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flt_valid_i |=> $stable(addr_q)); // R6
  AST_RD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !flt_valid_i) |=> stat_q == '0); // R8
  AST_FLT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && flt_valid_i) |=> stat_q != '0); // R9
  AST_OVF_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_valid_i && stat_q != '0) |=> stat_q[0]); // R1
endmodule

// File: rtl/mfc_trap_gate.sv
module mfc_trap_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flt_valid_i,
  input  logic mmu_en_i,
  input  logic mmu_nofault_i,
  output logic trap_o
);
  logic trap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trap_q <= 1'b0;
    else         trap_q <= flt_valid_i & mmu_en_i & ~mmu_nofault_i;
  end

  assign trap_o = trap_q;

  AST_TRAP_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_valid_i && mmu_en_i && !mmu_nofault_i) |=> trap_q); // R7
  AST_TRAP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flt_valid_i && mmu_en_i && !mmu_nofault_i) |=> !trap_q); // R7
endmodule

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture
  import mfc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned STAT_W  = 32,
  parameter int unsigned FT_CODE = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flt_valid_i,
  input  logic [ADDR_W-1:0] flt_addr_i,
  input  logic              flt_write_i,
  input  logic              flt_fetch_i,
  input  logic              flt_alt_i,
  input  logic              sup_mode_i,
  input  logic              mmu_en_i,
  input  logic              mmu_nofault_i,
  input  logic              stat_rd_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              trap_o
);
  flt_attr_t         attr;
  logic [STAT_W-1:0] new_word;
  logic [STAT_W-1:0] stat_cur;

  assign attr = '{alt: flt_alt_i, sup: sup_mode_i, fetch: flt_fetch_i, wr: flt_write_i};

  mfc_stat_build #(.STAT_W(STAT_W), .FT_CODE(FT_CODE)) u_build (
    .prev_nz_i (|stat_cur),
    .attr_i    (attr),
    .word_o    (new_word)
  );

  mfc_regs #(.STAT_W(STAT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flt_valid_i (flt_valid_i),
    .flt_addr_i  (flt_addr_i),
    .new_word_i  (new_word),
    .rd_i        (stat_rd_i),
    .stat_o      (stat_cur),
    .addr_o      (addr_o)
  );

  mfc_trap_gate u_trap (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .flt_valid_i   (flt_valid_i),
    .mmu_en_i      (mmu_en_i),
    .mmu_nofault_i (mmu_nofault_i),
    .trap_o        (trap_o)
  );

  assign stat_o = stat_cur;

  AST_ALT_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_valid_i |=> stat_o[ALT_BIT] == $past(flt_alt_i)); // R2
  AST_SUP_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_valid_i |=> stat_o[SUP_BIT] == $past(sup_mode_i)); // R3
  AST_ACC_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_valid_i |=> (stat_o[FETCH_BIT] == $past(flt_fetch_i)) && (stat_o[WR_BIT] == $past(flt_write_i))); // R4
endmodule

// File: tb/mmu_fault_capture_tb.sv
module mmu_fault_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flt_valid = 1'b0;
  logic [31:0] flt_addr = '0;
  logic        flt_write = 1'b0, flt_fetch = 1'b0, flt_alt = 1'b0;
  logic        sup_mode = 1'b0, mmu_en = 1'b0, mmu_nf = 1'b0, stat_rd = 1'b0;
  logic [31:0] stat, addr;
  logic        trap;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mmu_fault_capture dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .flt_valid_i(flt_valid), .flt_addr_i(flt_addr),
    .flt_write_i(flt_write), .flt_fetch_i(flt_fetch), .flt_alt_i(flt_alt),
    .sup_mode_i(sup_mode), .mmu_en_i(mmu_en), .mmu_nofault_i(mmu_nf),
    .stat_rd_i(stat_rd), .stat_o(stat), .addr_o(addr), .trap_o(trap)
  );

  // {addr, alt, sup, fetch, write, en, nofault}
  localparam logic [37:0] VEC [8] = '{
    {32'h0000_1000, 6'b000010},
    {32'hFFFF_FFFC, 6'b100011},
    {32'h8000_0004, 6'b010110},
    {32'h1234_5678, 6'b001010},
    {32'hDEAD_BEEF, 6'b111110},
    {32'h0000_0000, 6'b000100},
    {32'h7FFF_0001, 6'b101001},
    {32'hA5A5_5A5A, 6'b010010}
  };

  function automatic logic [31:0] exp_word(bit ovf, bit alt, bit sup, bit fch, bit wr);
    return {15'b0, alt, 8'b0, wr, fch, sup, 3'd5, 1'b1, ovf};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic drive_flt(logic [31:0] a, bit alt, bit sup, bit fch, bit wr, bit en, bit nf);
    flt_valid = 1'b1; flt_addr = a; flt_alt = alt; sup_mode = sup;
    flt_fetch = fch; flt_write = wr; mmu_en = en; mmu_nf = nf;
  endtask

  task automatic idle();
    flt_valid = 1'b0; stat_rd = 1'b0; flt_alt = 1'b0; sup_mode = 1'b0;
    flt_fetch = 1'b0; flt_write = 1'b0; mmu_en = 1'b0; mmu_nf = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [37:0] v;
    logic [31:0] w;
    repeat (2) @(negedge clk);
    check("R10 stat reset", stat, 32'h0);
    check("R10 addr reset", addr, 32'h0);
    check("R10 trap reset", {31'b0, trap}, 32'h0);
    rst_ni = 1'b1;
    cyc();

    for (int i = 0; i < 8; i++) begin
      v = VEC[i];
      drive_flt(v[37:6], v[5], v[4], v[3], v[2], v[1], v[0]);
      cyc();
      idle();
      w = exp_word(1'b0, v[5], v[4], v[3], v[2]);
      check("R2/R3/R4/R5 status word", stat, w);
      check("R6 address", addr, v[37:6]);
      check("R7 trap gate", {31'b0, trap}, {31'b0, v[1] & ~v[0]});
      stat_rd = 1'b1;
      check("R8 read shows status", stat, w);
      cyc();
      stat_rd = 1'b0;
      check("R7 trap one cycle", {31'b0, trap}, 32'h0);
      check("R8 cleared", stat, 32'h0);
      check("R6 addr kept on read", addr, v[37:6]);
    end

    // R1: back-to-back faults without a read
    drive_flt(32'h0000_0100, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    cyc();
    drive_flt(32'h0000_0200, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    cyc();
    idle();
    check("R1 overflow set", stat, exp_word(1'b1, 1'b1, 1'b0, 1'b0, 1'b1));
    check("R6 newest address", addr, 32'h0000_0200);
    check("R7 trap on second fault", {31'b0, trap}, 32'h1);

    // R9: fault coincides with read while status non-zero
    drive_flt(32'h0000_0300, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    stat_rd = 1'b1;
    cyc();
    idle();
    check("R9 fault wins over read", stat, exp_word(1'b1, 1'b0, 1'b0, 1'b1, 1'b0));
    check("R7 no trap when disabled", {31'b0, trap}, 32'h0);

    // R8: read clears, next fault finds zero so no overflow
    stat_rd = 1'b1;
    cyc();
    idle();
    check("R8 read clears", stat, 32'h0);
    drive_flt(32'h0000_0400, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    cyc();
    idle();
    check("R1 no overflow after clear", stat, exp_word(1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    check("R7 no trap when no-fault on", {31'b0, trap}, 32'h0);

    // R9: fault with read while status zero
    stat_rd = 1'b1;
    cyc();
    drive_flt(32'h0000_0500, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    stat_rd = 1'b1;
    cyc();
    idle();
    check("R9 fault wins from zero", stat, exp_word(1'b0, 1'b1, 1'b1, 1'b1, 1'b1));
    check("R7 trap with read", {31'b0, trap}, 32'h1);

    // R10: reset mid-run
    rst_ni = 1'b0;
    #1;
    check("R10 stat cleared by reset", stat, 32'h0);
    check("R10 addr cleared by reset", addr, 32'h0);
    check("R10 trap cleared by reset", {31'b0, trap}, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    cyc();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule